// File: doc/BRIEF.md
# Configurable-Trellis LLR Combiner

This block sits at the end of a max-log soft-in soft-out decoder. On each trellis step it takes the forward metric of every state, the backward metric of every state, and the branch metric of every (state, input bit) transition. It forms the candidate alpha + gamma + beta for each transition. It then takes the largest candidate among transitions driven by input bit 1 and, separately, among those driven by input bit 0. The difference between the two maxima is the a-posteriori log-likelihood ratio, and its sign is the decoded bit.

The trellis size follows a constraint-length selector covering K = 3, 4 and 5, so 4, 8 or 16 states are active. Transitions that leave an inactive state are forced to a floor value and never win a comparison. Two identical per-hypothesis units each do the summing and the two compare stages. A shared final stage subtracts, saturates and slices the sign. The latency is fixed at four cycles, and a new step can be accepted on every cycle.

Top module: `llr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge shows `out_valid` = 0, `llr` = 0 and `hard_bit` = 0. These values also stay until the first result arrives.
- R2: A step accepted with `in_valid` high at clock edge n gives `out_valid` high after edge n+4, for exactly one cycle. Back-to-back steps give back-to-back results in the same order, and `out_valid` is low otherwise.
- R3: For state s and bit u, the candidate is alpha[s] + gamma[2s+u] + beta[d], where d = (2s+u) mod N and N is the active state count. alpha[s] and beta[s] occupy bits s*12 +: 12 of their buses, and gamma[j] occupies bits j*10 +: 10. All values are signed two's complement.
- R4: The unsaturated LLR equals the largest u=1 candidate minus the largest u=0 candidate, taken over the active states.
- R5: `k_sel` = 0 selects N = 4 (K=3), 1 selects N = 8 (K=4), and 2 or 3 selects N = 16 (K=5). The metrics of states s ≥ N have no effect on the result, whatever their values.
- R6: `llr` is 12-bit two's complement. Differences above 2047 give 2047, and differences below -2048 give -2048.
- R7: `hard_bit` is 1 exactly when the difference is positive. A difference of zero gives 0.
- R8: In cycles where `out_valid` is low, `llr` and `hard_bit` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Metric buses hold a step to process |
| k_sel | input | 2 | Constraint-length selector (R5 encoding) |
| alpha_flat | input | 192 | 16 forward metrics, 12-bit signed each |
| beta_flat | input | 192 | 16 backward metrics, 12-bit signed each |
| gamma_flat | input | 320 | 32 branch metrics, 10-bit signed, index 2s+u |
| out_valid | output | 1 | LLR and hard bit are new this cycle |
| llr | output | 12 | Saturated log-likelihood ratio |
| hard_bit | output | 1 | Decoded bit |

## Verification
The assertions assume that `in_valid` is low during reset and that inputs settle well away from the clock edge. The stimulus meets both conditions: it drives only on falling edges and holds `in_valid` at zero until reset is released. The latency property also relies on a count of edges since reset, because it must not compare against cycles inside reset. The stimulus covers the following:
- large metrics parked in the inactive states for each K;
- metric patterns chosen to push the difference past both rails and to land it on exactly zero;
- random runs that mix gaps with back-to-back steps, so that the hold behaviour and the result ordering are both exercised.

// File: rtl/llr_pkg.sv
// Shared definitions for the LLR combiner.
// Assumes the largest supported trellis has at least 4 states.
package llr_pkg;

    typedef enum logic [1:0] {
        KSEL_K3  = 2'd0,
        KSEL_K4  = 2'd1,
        KSEL_K5  = 2'd2,
        KSEL_K5B = 2'd3
    } ksel_e;

    // Active state count for a selector code, capped at the built trellis size.
    function automatic int active_states(input logic [1:0] ksel, input int ns);
        int n;
        case (ksel_e'(ksel))
            KSEL_K3: n = 4;
            KSEL_K4: n = 8;
            default: n = 16;
        endcase
        return (n > ns) ? ns : n;
    endfunction

endpackage

// File: rtl/llr_hyp_max.sv
// One bit-hypothesis unit. It forms alpha+gamma+beta for every transition
// driven by input bit HYP (stage 1), reduces groups of four-way partitions
// (stage 2), and then reduces to a single maximum (stage 3).
// Assumes NS is a multiple of 4 and that SUMW holds the sum of three inputs.
module llr_hyp_max
    import llr_pkg::*;
#(
    parameter int NS   = 16,
    parameter int MW   = 12,
    parameter int GW   = 10,
    parameter int SUMW = 14,
    parameter int HYP  = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_sum,
    input  logic                       en_part,
    input  logic                       en_best,
    input  logic [1:0]                 k_sel,
    input  logic [NS*MW-1:0]           alpha_flat,
    input  logic [NS*MW-1:0]           beta_flat,
    input  logic [2*NS*GW-1:0]         gamma_flat,
    output logic signed [SUMW-1:0]     best
);
    localparam int GRP = NS / 4;
    localparam logic signed [SUMW-1:0] FLOOR = {1'b1, {(SUMW-1){1'b0}}};

    logic signed [SUMW-1:0] cand_d [NS];
    logic signed [SUMW-1:0] cand_q [NS];
    logic signed [SUMW-1:0] part_d [4];
    logic signed [SUMW-1:0] part_q [4];
    logic signed [SUMW-1:0] best_d;

    // Candidate per source state, masked to the floor when the state is inactive.
    always_comb begin
        int act;
        int dst;
        logic signed [MW-1:0] a_v;
        logic signed [MW-1:0] b_v;
        logic signed [GW-1:0] g_v;
        act = active_states(k_sel, NS);
        for (int s = 0; s < NS; s++) begin
            dst = (2 * s + HYP) & (act - 1);
            a_v = alpha_flat[s*MW +: MW];
            b_v = beta_flat[dst*MW +: MW];
            g_v = gamma_flat[(2*s+HYP)*GW +: GW];
            if (s < act)
                cand_d[s] = SUMW'(a_v) + SUMW'(g_v) + SUMW'(b_v);
            else
                cand_d[s] = FLOOR;
        end
    end

    // Stage 1 register: candidates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) cand_q[s] <= '0;
        end else if (en_sum) begin
            for (int s = 0; s < NS; s++) cand_q[s] <= cand_d[s];
        end
    end

    // First compare level: maximum within each of four groups.
    always_comb begin
        for (int g = 0; g < 4; g++) begin
            part_d[g] = cand_q[g*GRP];
            for (int j = 1; j < GRP; j++)
                if (cand_q[g*GRP+j] > part_d[g]) part_d[g] = cand_q[g*GRP+j];
        end
    end

    // Stage 2 register: group maxima.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 4; g++) part_q[g] <= '0;
        end else if (en_part) begin
            for (int g = 0; g < 4; g++) part_q[g] <= part_d[g];
        end
    end

    // Second compare level: overall maximum.
    always_comb begin
        best_d = part_q[0];
        for (int g = 1; g < 4; g++)
            if (part_q[g] > best_d) best_d = part_q[g];
    end

    // Stage 3 register: hypothesis maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)       best <= '0;
        else if (en_best) best <= best_d;
    end

endmodule

// File: rtl/llr_sub_sat.sv
// Final stage: difference of the two hypothesis maxima, saturated to LW bits,
// plus the sign slice for the hard decision. Holds its outputs when not enabled.
// Assumes SUMW + 1 > LW.
module llr_sub_sat #(
    parameter int SUMW = 14,
    parameter int LW   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic signed [SUMW-1:0] max_one,
    input  logic signed [SUMW-1:0] max_zero,
    output logic [LW-1:0]          llr,
    output logic                   hard_bit
);
    localparam int DW = SUMW + 1;
    localparam logic signed [DW-1:0] HI = DW'((2 ** (LW - 1)) - 1);
    localparam logic signed [DW-1:0] LO = -HI - DW'(1);

    logic signed [DW-1:0] diff;
    logic [LW-1:0]        sat;

    // Wide difference and clamp to the output range.
    always_comb begin
        diff = DW'(max_one) - DW'(max_zero);
        if (diff > HI)      sat = HI[LW-1:0];
        else if (diff < LO) sat = LO[LW-1:0];
        else                sat = diff[LW-1:0];
    end

    // Stage 4 register: result, held between valid steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            llr      <= '0;
            hard_bit <= 1'b0;
        end else if (en) begin
            llr      <= sat;
            hard_bit <= (diff > DW'(0));
        end
    end

endmodule

// File: rtl/llr_unit.sv
// Top of the LLR combiner: two hypothesis units in parallel, a shared
// subtract/saturate stage and a four-deep valid pipeline.
// Assumes MAXK >= 3; the active trellis size is chosen per step by k_sel.
module llr_unit #(
    parameter int MAXK = 5,
    parameter int MW   = 12,
    parameter int GW   = 10,
    parameter int LW   = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [1:0]                     k_sel,
    input  logic [(2**(MAXK-1))*MW-1:0]    alpha_flat,
    input  logic [(2**(MAXK-1))*MW-1:0]    beta_flat,
    input  logic [2*(2**(MAXK-1))*GW-1:0]  gamma_flat,
    output logic                           out_valid,
    output logic [LW-1:0]                  llr,
    output logic                           hard_bit
);
    localparam int NS    = 2 ** (MAXK - 1);
    localparam int SUMW  = MW + 2;
    localparam int DEPTH = 4;

    logic [DEPTH-1:0]       vld_q;
    logic signed [SUMW-1:0] hyp_best [2];

    // Valid pipeline, one bit per stage.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[DEPTH-2:0], in_valid};
    end

    generate
        for (genvar b = 0; b < 2; b++) begin : g_hyp
            llr_hyp_max #(
                .NS(NS), .MW(MW), .GW(GW), .SUMW(SUMW), .HYP(b)
            ) u_hyp (
                .clk        (clk),
                .rst_n      (rst_n),
                .en_sum     (in_valid),
                .en_part    (vld_q[0]),
                .en_best    (vld_q[1]),
                .k_sel      (k_sel),
                .alpha_flat (alpha_flat),
                .beta_flat  (beta_flat),
                .gamma_flat (gamma_flat),
                .best       (hyp_best[b])
            );
        end
    endgenerate

    llr_sub_sat #(.SUMW(SUMW), .LW(LW)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (vld_q[2]),
        .max_one  (hyp_best[1]),
        .max_zero (hyp_best[0]),
        .llr      (llr),
        .hard_bit (hard_bit)
    );

    assign out_valid = vld_q[DEPTH-1];

endmodule

// File: rtl/llr_unit_chk.sv
// Protocol checks for llr_unit, attached by bind.
// Assumes in_valid is held low while reset is asserted.
module llr_unit_chk #(
    parameter int LW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [LW-1:0] llr,
    input logic          hard_bit
);
    logic [2:0] since_rst;

    // Edges seen since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 7) since_rst <= since_rst + 3'd1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && llr == '0 && !hard_bit));

    a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    a_r7_sign_matches: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (hard_bit == ($signed(llr) > 0)));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && !out_valid) |-> ($stable(llr) && $stable(hard_bit)));

endmodule

bind llr_unit llr_unit_chk #(.LW(LW)) u_chk (.*);

// File: tb/llr_unit_bench.sv
`timescale 1ns/1ps
// Bench for llr_unit: behavioural reference with a queue of expected results.
module llr_unit_bench;
    localparam int NS = 16;
    localparam int MW = 12;
    localparam int GW = 10;
    localparam int LW = 12;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [1:0]            k_sel = '0;
    logic [NS*MW-1:0]      alpha_flat = '0;
    logic [NS*MW-1:0]      beta_flat = '0;
    logic [2*NS*GW-1:0]    gamma_flat = '0;
    logic                  out_valid;
    logic [LW-1:0]         llr;
    logic                  hard_bit;

    int a_i [NS];
    int b_i [NS];
    int g_i [2*NS];

    int    q_v[$];
    int    q_llr[$];
    string q_tag[$];
    int    last_llr = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always #2.5 clk = ~clk;

    llr_unit u_llr_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .k_sel(k_sel),
        .alpha_flat(alpha_flat), .beta_flat(beta_flat), .gamma_flat(gamma_flat),
        .out_valid(out_valid), .llr(llr), .hard_bit(hard_bit)
    );

    function automatic int ref_llr(input int k);
        int n, m1, m0, d, c, df;
        n  = (k == 0) ? 4 : (k == 1) ? 8 : 16;
        m1 = -100000;
        m0 = -100000;
        for (int s = 0; s < n; s++) begin
            for (int u = 0; u < 2; u++) begin
                d = (2 * s + u) % n;
                c = a_i[s] + g_i[2*s+u] + b_i[d];
                if (u == 1) begin if (c > m1) m1 = c; end
                else        begin if (c > m0) m0 = c; end
            end
        end
        df = m1 - m0;
        if (df > 2047)  df = 2047;
        if (df < -2048) df = -2048;
        return df;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare outputs against the entry driven four falling edges ago.
    task automatic compare_step();
        int    ev;
        int    el;
        string tg;
        int    got;
        if (q_v.size() == 4) begin
            ev = q_v.pop_front();
            el = q_llr.pop_front();
            tg = q_tag.pop_front();
        end else begin
            ev = 0; el = last_llr; tg = "R1";
        end
        got = int'($signed(llr));
        check({tg, " R2 out_valid"}, int'(out_valid), ev);
        if (ev != 0) begin
            check({tg, " llr"}, got, el);
            check({tg, " R7 hard_bit"}, int'(hard_bit), (el > 0) ? 1 : 0);
            last_llr = el;
        end else begin
            check("R8 llr held", got, last_llr);
            check("R8 hard_bit held", int'(hard_bit), (last_llr > 0) ? 1 : 0);
        end
    endtask

    task automatic tick(input bit v, input int k, input string tag);
        @(negedge clk);
        compare_step();
        in_valid = v;
        k_sel    = k[1:0];
        for (int s = 0; s < NS; s++) begin
            alpha_flat[s*MW +: MW] = a_i[s][MW-1:0];
            beta_flat[s*MW +: MW]  = b_i[s][MW-1:0];
        end
        for (int j = 0; j < 2*NS; j++) gamma_flat[j*GW +: GW] = g_i[j][GW-1:0];
        q_v.push_back(v ? 1 : 0);
        q_llr.push_back(v ? ref_llr(k) : 0);
        q_tag.push_back(tag);
    endtask

    task automatic fill_random();
        for (int s = 0; s < NS; s++) begin
            a_i[s] = int'($urandom_range(4095)) - 2048;
            b_i[s] = int'($urandom_range(4095)) - 2048;
        end
        for (int j = 0; j < 2*NS; j++) g_i[j] = int'($urandom_range(1023)) - 512;
    endtask

    task automatic fill_const(input int a, input int b, input int g);
        for (int s = 0; s < NS; s++) begin a_i[s] = a; b_i[s] = b; end
        for (int j = 0; j < 2*NS; j++) g_i[j] = g;
    endtask

    initial begin
        fill_const(0, 0, 0);
        // R1: reset state while reset is held
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset llr", int'($signed(llr)), 0);
        check("R1 reset hard_bit", int'(hard_bit), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: all-zero metrics give exactly zero, hard bit 0
        tick(1, 2, "R7 zero");
        // R3/R4: hand pattern, one strong bit-1 path for K=5
        fill_const(-100, -100, 0);
        a_i[5] = 300; g_i[11] = 50; b_i[11] = 200;
        tick(1, 2, "R3 R4 single path");
        // R6: positive saturation
        fill_const(0, 0, 0);
        for (int s = 0; s < NS; s++) b_i[s] = (s % 2 == 1) ? 2047 : -2048;
        for (int j = 0; j < 2*NS; j++) g_i[j] = (j % 2 == 1) ? 511 : -512;
        tick(1, 2, "R6 high rail");
        // R6: negative saturation
        for (int s = 0; s < NS; s++) b_i[s] = (s % 2 == 1) ? -2048 : 2047;
        for (int j = 0; j < 2*NS; j++) g_i[j] = (j % 2 == 1) ? -512 : 511;
        tick(1, 2, "R6 low rail");
        tick(0, 0, "idle");
        tick(0, 0, "idle");

        // R5: large metrics parked in inactive states must not matter
        for (int k = 0; k < 4; k++) begin
            int n;
            n = (k == 0) ? 4 : (k == 1) ? 8 : 16;
            fill_random();
            for (int s = n; s < NS; s++) begin a_i[s] = 2047; b_i[s] = 2047; end
            for (int j = 2*n; j < 2*NS; j++) g_i[j] = 511;
            tick(1, k, "R5 inactive states");
        end
        tick(0, 0, "idle");

        // R2/R3/R4/R8: random mix of gaps and back-to-back steps
        for (int i = 0; i < 400; i++) begin
            fill_random();
            tick(($urandom_range(3) != 0), int'($urandom_range(3)), "R3 R4 random");
        end
        repeat (6) tick(0, 0, "drain");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule